// File: doc/BRIEF.md
# Program Phase Change Monitor

This controller decides when the set of hot basic blocks held in a small level-0 instruction cache no longer matches what the program is running. It has two stages. In the profiling stage it counts the cache lines that the fetch unit reports as promoted into the level-0 cache. When a fixed line budget is used up, the cache is full, and the controller moves to the monitoring stage. On entry it tells the branch target buffer to drop every previous-phase flag.

In the monitoring stage an 8-bit balance counter starts at 128. Every resolved branch that lands on a hot block moves it down by one, saturating at zero. Every branch that lands on a non-hot block moves it up by one. An increment from 255 means too few executions were hot. The controller then issues a phase-reset command, so the buffer clears its hot flags and execution counters, and it returns to profiling to pick a new hot set.

The inputs are one-cycle pulses: a branch-executed strobe with a hot tag, and a promotion-done strobe. The outputs are the current stage and the two single-cycle commands. All outputs are registered.

Top module: `phase_monitor_top`

## Requirements
- R1: After reset, `stage` is 0 (profiling; 1 means monitoring), and `phase_reset` and `clr_prev_hot` are both low.
- R2: While profiling, `stage` stays 0 until `PROMO_LINES` promotion pulses (default 16) have been counted. The clock edge that samples the last one sets `stage` to 1.
- R3: `clr_prev_hot` is high for exactly one cycle, in the first cycle that `stage` reads 1. It is low at all other times.
- R4: The balance counter is loaded with 128 on every entry to monitoring. With only non-hot branches, 127 of them cause no phase reset, and the 128th does.
- R5: A branch pulse with `br_hot`=1 lowers the counter by one. `br_hot` has no effect while `br_valid` is low. After k hot branches (k < 128), exactly 128+k non-hot branches are needed to overflow.
- R6: Decrements saturate at 0. After 128 or more hot branches, 255 non-hot branches cause no phase reset, and the 256th does.
- R7: The overflowing branch makes `phase_reset` high for exactly one cycle, in the cycle after that branch is sampled. `stage` returns to 0 in that same cycle.
- R8: Branch pulses received while profiling do not change the balance counter. After any number of them, the next monitoring stage still needs exactly 128 non-hot branches to overflow.
- R9: Promotion pulses received while monitoring are ignored: they cause no change of stage and no `clr_prev_hot`. After a phase reset, the line count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | One-cycle pulse: a branch was resolved as executed |
| br_hot | input | 1 | The executed branch targets a hot block (used only when `br_valid` is high) |
| promo_done | input | 1 | One-cycle pulse: one line was promoted into the level-0 cache |
| stage | output | 1 | 0 = profiling, 1 = monitoring (registered) |
| phase_reset | output | 1 | One-cycle command: clear hot flags and execution counters |
| clr_prev_hot | output | 1 | One-cycle command: clear all previous-phase flags |

## Verification
The balance counter and the line count are internal, so errors in them can only be seen through the timing of the stage change and the two command pulses.

- **Balance counter:** a wrong reload value, a missing decrement or a missing floor at zero moves the `phase_reset` pulse earlier or later than expected. A run of exactly 127/128, 137/138 or 255/256 non-hot branches shows the error within one cycle of the expected overflow point.
- **Line count:** a count that leaks across stages, or is not cleared after a phase reset, makes `stage` rise one or more promotion pulses too early or too late.
- **Stage register:** a stuck or misordered stage shows up as a `clr_prev_hot` or `phase_reset` pulse that is misaligned with the change of `stage`.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic {
    ST_PROFILE = 1'b0,
    ST_MONITOR = 1'b1
  } pcm_stage_e;
endpackage

// File: rtl/pcm_line_budget.sv
module pcm_line_budget #(
  parameter int LINES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic full_evt
);
  localparam int CW = $clog2(LINES + 1);
  localparam logic [CW-1:0] LAST = CW'(LINES - 1);

  logic [CW-1:0] cnt_q;

  assign full_evt = inc && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: the line count never reaches the budget value itself
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(LINES));

  // R9: with no promotion and no clear, the count holds
  a_r9_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/pcm_balance_ctr.sv
module pcm_balance_ctr #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic en,
  input  logic up,
  input  logic dn,
  output logic ovf_evt
);
  localparam logic [W-1:0] INIT = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] TOP  = {W{1'b1}};

  logic [W-1:0] bal_q;

  assign ovf_evt = en && !load && up && !dn && (bal_q == TOP);

  always_ff @(posedge clk) begin
    if (rst || load) begin
      bal_q <= INIT;
    end else if (en) begin
      if (up && !dn && bal_q != TOP)
        bal_q <= bal_q + 1'b1;
      else if (dn && !up && bal_q != '0)
        bal_q <= bal_q - 1'b1;
    end
  end

  // R6: a decrement at zero leaves the counter at zero
  a_r6_floor: assert property (@(posedge clk) disable iff (rst)
    (en && !load && dn && !up && bal_q == '0) |=> (bal_q == '0));

  // R8: outside monitoring the counter does not move
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(bal_q));

  // R4: every load gives the midpoint value
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    load |=> (bal_q == INIT));
endmodule

// File: rtl/pcm_stage_ctl.sv
module pcm_stage_ctl
  import pcm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       full_evt,
  input  logic       ovf_evt,
  output pcm_stage_e stage_q,
  output logic       phase_reset_q,
  output logic       clr_prev_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q       <= ST_PROFILE;
      phase_reset_q <= 1'b0;
      clr_prev_q    <= 1'b0;
    end else begin
      phase_reset_q <= 1'b0;
      clr_prev_q    <= 1'b0;
      case (stage_q)
        ST_PROFILE: if (full_evt) begin
          stage_q    <= ST_MONITOR;
          clr_prev_q <= 1'b1;
        end
        ST_MONITOR: if (ovf_evt) begin
          stage_q       <= ST_PROFILE;
          phase_reset_q <= 1'b1;
        end
        default: stage_q <= ST_PROFILE;
      endcase
    end
  end

  logic in_mon;
  assign in_mon = (stage_q == ST_MONITOR);

  // R3: the clear command comes with entry to monitoring and only then
  a_r3_clr_in_mon: assert property (@(posedge clk) disable iff (rst)
    clr_prev_q |-> in_mon);
  a_r3_clr_on_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(in_mon) |-> clr_prev_q);
  a_r3_clr_single: assert property (@(posedge clk) disable iff (rst)
    clr_prev_q |=> !clr_prev_q);

  // R7: a phase reset comes with the return to profiling, one cycle long
  a_r7_reset_on_exit: assert property (@(posedge clk) disable iff (rst)
    $fell(in_mon) |-> phase_reset_q);
  a_r7_reset_in_prof: assert property (@(posedge clk) disable iff (rst)
    phase_reset_q |-> !in_mon);
  a_r7_reset_single: assert property (@(posedge clk) disable iff (rst)
    phase_reset_q |=> !phase_reset_q);
endmodule

// File: rtl/phase_monitor_top.sv
module phase_monitor_top
  import pcm_pkg::*;
#(
  parameter int PROMO_LINES = 16,
  parameter int BAL_W       = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic br_valid,
  input  logic br_hot,
  input  logic promo_done,
  output logic stage,
  output logic phase_reset,
  output logic clr_prev_hot
);
  pcm_stage_e st;
  logic       in_prof;
  logic       in_mon;
  logic       full_evt;
  logic       ovf_evt;
  logic       pr_q;
  logic       cp_q;

  assign in_prof = (st == ST_PROFILE);
  assign in_mon  = (st == ST_MONITOR);

  pcm_line_budget #(.LINES(PROMO_LINES)) u_budget (
    .clk      (clk),
    .rst      (rst),
    .clr      (ovf_evt),
    .inc      (promo_done && in_prof),
    .full_evt (full_evt)
  );

  pcm_balance_ctr #(.W(BAL_W)) u_balance (
    .clk     (clk),
    .rst     (rst),
    .load    (full_evt),
    .en      (in_mon),
    .up      (br_valid && !br_hot),
    .dn      (br_valid && br_hot),
    .ovf_evt (ovf_evt)
  );

  pcm_stage_ctl u_ctl (
    .clk           (clk),
    .rst           (rst),
    .full_evt      (full_evt),
    .ovf_evt       (ovf_evt),
    .stage_q       (st),
    .phase_reset_q (pr_q),
    .clr_prev_q    (cp_q)
  );

  assign stage        = in_mon;
  assign phase_reset  = pr_q;
  assign clr_prev_hot = cp_q;

  // R9: promotions while monitoring never re-trigger the clear command
  a_r9_no_clr_in_mon: assert property (@(posedge clk) disable iff (rst)
    (in_mon && promo_done) |=> !clr_prev_hot);
  // R1: the two commands are never asserted together
  a_r1_cmds_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(phase_reset && clr_prev_hot));
endmodule

// File: tb/tb_phase_monitor_top.sv
module tb_phase_monitor_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINES      = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic br_valid = 1'b0;
  logic br_hot = 1'b0;
  logic promo_done = 1'b0;
  logic stage, phase_reset, clr_prev_hot;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_monitor_top #(.PROMO_LINES(LINES), .BAL_W(8)) dut (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_hot(br_hot),
    .promo_done(promo_done), .stage(stage), .phase_reset(phase_reset),
    .clr_prev_hot(clr_prev_hot)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle of stimulus; returns at the next falling edge with inputs idle
  task automatic step(input logic p, input logic bv, input logic bh);
    promo_done = p; br_valid = bv; br_hot = bh;
    @(negedge clk);
    promo_done = 1'b0; br_valid = 1'b0; br_hot = 1'b0;
  endtask

  // drive n branch pulses; report whether a phase reset showed up
  task automatic branches(input int n, input logic hot, output bit saw_pr);
    saw_pr = 0;
    for (int i = 0; i < n; i++) begin
      step(1'b0, 1'b1, hot);
      if (phase_reset) saw_pr = 1;
    end
  endtask

  task automatic fill_cache(input string req);
    for (int i = 0; i < LINES - 1; i++) step(1'b1, 1'b0, 1'b0);
    check({req, " stage before last line"}, stage, 0);
    step(1'b1, 1'b0, 1'b0);
    check({req, " stage after last line"}, stage, 1);
    check("R3 clr_prev_hot on entry", clr_prev_hot, 1);
    step(1'b0, 1'b0, 1'b0);
    check("R3 clr_prev_hot single cycle", clr_prev_hot, 0);
  endtask

  task automatic t_reset();
    check("R1 stage", stage, 0);
    check("R1 phase_reset", phase_reset, 0);
    check("R1 clr_prev_hot", clr_prev_hot, 0);
  endtask

  task automatic t_profile_branches();
    bit pr;
    branches(300, 1'b0, pr);
    check("R8 no reset while profiling", pr, 0);
    check("R8 stage while profiling", stage, 0);
    fill_cache("R2");
    branches(127, 1'b0, pr);
    check("R4 no reset after 127", pr, 0);
    check("R4 stage after 127", stage, 1);
    step(1'b0, 1'b1, 1'b0);
    check("R4 reset at 128th", phase_reset, 1);
    check("R7 stage back to profiling", stage, 0);
    step(1'b0, 1'b0, 1'b0);
    check("R7 phase_reset single cycle", phase_reset, 0);
  endtask

  task automatic t_hot_balance();
    bit pr;
    fill_cache("R2");
    branches(10, 1'b1, pr);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b1);
    branches(137, 1'b0, pr);
    check("R5 no reset after 137 non-hot", pr, 0);
    step(1'b0, 1'b1, 1'b0);
    check("R5 reset at 138th", phase_reset, 1);
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_saturate();
    bit pr;
    fill_cache("R2");
    branches(200, 1'b1, pr);
    check("R6 no reset on hot run", pr, 0);
    branches(255, 1'b0, pr);
    check("R6 no reset after 255 non-hot", pr, 0);
    check("R6 still monitoring", stage, 1);
    step(1'b0, 1'b1, 1'b0);
    check("R6 reset at 256th", phase_reset, 1);
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_promo_in_monitor();
    bit pr;
    bit saw_cp = 0;
    fill_cache("R9");
    for (int i = 0; i < 40; i++) begin
      step(1'b1, 1'b0, 1'b0);
      if (clr_prev_hot || !stage) saw_cp = 1;
    end
    check("R9 promotions ignored in monitoring", saw_cp, 0);
    branches(128, 1'b0, pr);
    check("R9 overflow still at 128", pr, 1);
    step(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < LINES - 1; i++) step(1'b1, 1'b0, 1'b0);
    check("R9 budget restarted after reset", stage, 0);
    step(1'b1, 1'b0, 1'b0);
    check("R9 entry after full budget", stage, 1);
    branches(128, 1'b0, pr);
    check("R4 second entry reload", pr, 1);
    step(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_profile_branches();
    t_hot_balance();
    t_saturate();
    t_promo_in_monitor();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule